// File: doc/BRIEF.md
# Boot Source Selection Latch

This block decides which memory the processor starts from after reset. It combines an external boot pin with four stored configuration bits (a lock, a secondary select, a choice between pin and stored value, and a stored boot value) and an empty-device flag. From these it produces a 2-bit boot area code: main flash, system memory (the loader) or SRAM.

The decision is captured when the external reset input goes high, and again when a standby-exit strobe pulses. Between those events the code stays fixed. A debugger-detection input, seen while the boot value is taken from the pin, arms a sticky override. While the override is armed, the pin reads as 0. Only the power-on reset clears it.

A valid flag stays low from power-on until the first capture. All logic runs on one clock, and the external reset input is sampled as an ordinary synchronous signal.

Top module: `boot_area_latch`

## Requirements
- R1: If the lock bit is 1 at capture, the boot area is main flash (code 2'b00), whatever the pin, the other bits, the empty flag and the debugger override say.
- R2: With lock 0 and the source select 0, the pin decides. Pin 0 gives main flash. Pin 1 gives system memory (2'b01) when the secondary bit is 1, and SRAM (2'b10) when it is 0.
- R3: With lock 0 and the source select 1, the stored boot value decides. Value 1 gives main flash. Value 0 gives system memory or SRAM, chosen by the secondary bit as in R2.
- R4: If lock is 0 and the rules would pick main flash while the empty flag is 1, the code is system memory (2'b01) instead.
- R5: A capture happens in the clock edge where the external reset input is first seen high after being low, or where the standby-exit strobe is high. The result shows one clock later. At all other edges the code and the valid flag hold.
- R6: The override arms when debugger activity is seen while the source select is 0. Debugger activity with the source select at 1 does not arm it. Once armed, the override makes every later capture treat the pin as 0. It survives any number of external resets and standby exits.
- R7: Power-on reset clears the code to 2'b00, clears the valid flag and disarms the override. The valid flag rises only with the first capture.
- R8: The code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| ext_rst_n | input | 1 | External reset level; a low-to-high change triggers a capture |
| standby_exit | input | 1 | One-cycle strobe on wake from standby; triggers a capture |
| boot_pin | input | 1 | External boot pin level |
| cfg_lock | input | 1 | Lock bit forcing main flash |
| cfg_sec | input | 1 | Secondary select: 1 system memory, 0 SRAM |
| cfg_src_bit | input | 1 | Boot value source: 0 pin, 1 stored value |
| cfg_boot_val | input | 1 | Stored boot value |
| flash_empty | input | 1 | Empty-device flag |
| dbg_seen | input | 1 | Debugger activity detected |
| boot_area | output | 2 | 00 main flash, 01 system memory, 10 SRAM |
| boot_valid | output | 1 | High once a capture has happened since power-on |

## Verification
The bench sweeps all 64 input combinations through external-reset captures and also through standby-exit captures. A design that missed the empty redirect, or applied it under the lock, would boot from flash or the loader in the wrong rows. A design that armed the override regardless of the source select would give main flash where system memory is expected. A design that cleared the override on external reset would return to the pin after the first later reset. The bench also changes inputs without any capture edge to catch a latch that is transparent. It checks that power-on reset drops the valid flag and disarms the override.

// File: rtl/boot_area_latch.sv
module boot_area_latch (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       standby_exit,
  input  logic       boot_pin,
  input  logic       cfg_lock,
  input  logic       cfg_sec,
  input  logic       cfg_src_bit,
  input  logic       cfg_boot_val,
  input  logic       flash_empty,
  input  logic       dbg_seen,
  output logic [1:0] boot_area,
  output logic       boot_valid
);
  localparam logic [1:0] AREA_FLASH = 2'b00;
  localparam logic [1:0] AREA_SYS   = 2'b01;
  localparam logic [1:0] AREA_SRAM  = 2'b10;

  logic       ext_q;
  logic       dbg_armed;
  logic       capture;
  logic       pin_eff;
  logic       want_flash;
  logic [1:0] next_area;

  assign capture    = (ext_rst_n & ~ext_q) | standby_exit;
  assign pin_eff    = boot_pin & ~dbg_armed & ~(dbg_seen & ~cfg_src_bit);
  assign want_flash = cfg_src_bit ? cfg_boot_val : ~pin_eff;

  always_comb begin
    if (cfg_lock)        next_area = AREA_FLASH;
    else if (want_flash) next_area = flash_empty ? AREA_SYS : AREA_FLASH;
    else                 next_area = cfg_sec ? AREA_SYS : AREA_SRAM;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ext_q      <= 1'b1;
      dbg_armed  <= 1'b0;
      boot_area  <= AREA_FLASH;
      boot_valid <= 1'b0;
    end else begin
      ext_q <= ext_rst_n;
      if (dbg_seen && !cfg_src_bit) dbg_armed <= 1'b1;
      if (capture) begin
        boot_area  <= next_area;
        boot_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_area_latch_chk.sv
module boot_area_latch_chk (
  input logic       clk,
  input logic       por_n,
  input logic       capture,
  input logic       dbg_armed,
  input logic       boot_pin,
  input logic       cfg_lock,
  input logic       cfg_src_bit,
  input logic       flash_empty,
  input logic [1:0] boot_area,
  input logic       boot_valid
);
  assert_lock_flash_R1: assert property (@(posedge clk) disable iff (!por_n)
    capture && cfg_lock |=> boot_area == 2'b00);

  assert_pin_zero_flash_R2: assert property (@(posedge clk) disable iff (!por_n)
    capture && !cfg_lock && !cfg_src_bit && !boot_pin && !flash_empty |=> boot_area == 2'b00);

  assert_empty_redirect_R4: assert property (@(posedge clk) disable iff (!por_n)
    capture && !cfg_lock && !cfg_src_bit && !boot_pin && flash_empty |=> boot_area == 2'b01);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
    !capture |=> $stable(boot_area) && $stable(boot_valid));

  assert_override_R6: assert property (@(posedge clk) disable iff (!por_n)
    capture && dbg_armed && !cfg_lock && !cfg_src_bit && !flash_empty |=> boot_area == 2'b00);

  assert_override_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
    dbg_armed |=> dbg_armed);

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!por_n)
    !boot_valid && !capture |=> !boot_valid);

  assert_no_code3_R8: assert property (@(posedge clk) disable iff (!por_n)
    boot_area != 2'b11);
endmodule

bind boot_area_latch boot_area_latch_chk chk_i (
  .clk(clk), .por_n(por_n), .capture(capture), .dbg_armed(dbg_armed),
  .boot_pin(boot_pin), .cfg_lock(cfg_lock), .cfg_src_bit(cfg_src_bit),
  .flash_empty(flash_empty), .boot_area(boot_area), .boot_valid(boot_valid));

// File: tb/boot_area_latch_tb_top.sv
module boot_area_latch_tb_top;
  logic clk = 1'b0;
  logic por_n = 1'b0, ext_rst_n = 1'b1, standby_exit = 1'b0;
  logic boot_pin = 1'b0, cfg_lock = 1'b0, cfg_sec = 1'b0, cfg_src_bit = 1'b0;
  logic cfg_boot_val = 1'b0, flash_empty = 1'b0, dbg_seen = 1'b0;
  logic [1:0] boot_area;
  logic boot_valid;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  boot_area_latch dut_i (.*);

  function automatic logic [1:0] expect_area(logic [5:0] v, logic dbg);
    logic lk, sc, sr, bv, pn, em, fl;
    {lk, sc, sr, bv, pn, em} = v;
    if (lk) return 2'b00;
    fl = sr ? bv : !(pn && !dbg);
    if (fl) return em ? 2'b01 : 2'b00;
    return sc ? 2'b01 : 2'b10;
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] v);
    @(negedge clk);
    {cfg_lock, cfg_sec, cfg_src_bit, cfg_boot_val, boot_pin, flash_empty} = v;
  endtask

  task automatic ext_capture();
    @(negedge clk) ext_rst_n = 1'b0;
    @(negedge clk) ext_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic sb_capture();
    @(negedge clk) standby_exit = 1'b1;
    @(negedge clk) standby_exit = 1'b0;
  endtask

  task automatic req_of(logic [5:0] v, output string s);
    if (v[5]) s = "R1";
    else if (expect_area(v, 1'b0) == 2'b01 && v[0] &&
             (v[3] ? v[2] : !v[1])) s = "R4";
    else s = v[3] ? "R3" : "R2";
  endtask

  initial begin
    string r;
    repeat (3) @(negedge clk);
    check("R7 reset valid", {1'b0, boot_valid}, 2'b00);
    check("R7 reset area", boot_area, 2'b00);
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 no capture yet", {1'b0, boot_valid}, 2'b00);

    for (int i = 0; i < 64; i++) begin
      apply(6'(i));
      ext_capture();
      req_of(6'(i), r);
      check($sformatf("%s ext row %0d", r, i), boot_area, expect_area(6'(i), 1'b0));
      check("R7 valid after capture", {1'b0, boot_valid}, 2'b01);
    end
    for (int i = 0; i < 64; i++) begin
      apply(6'(i));
      sb_capture();
      req_of(6'(i), r);
      check($sformatf("%s standby row %0d", r, i), boot_area, expect_area(6'(i), 1'b0));
    end

    apply(6'b010010);
    ext_capture();
    check("R5 setup", boot_area, 2'b01);
    for (int i = 0; i < 64; i++) begin
      apply(6'(i));
      @(negedge clk);
      check("R5 hold without capture", boot_area, 2'b01);
    end

    apply(6'b011000);
    @(negedge clk) dbg_seen = 1'b1;
    @(negedge clk) dbg_seen = 1'b0;
    apply(6'b010010);
    ext_capture();
    check("R6 no arm with stored source", boot_area, 2'b01);

    @(negedge clk) dbg_seen = 1'b1;
    @(negedge clk) dbg_seen = 1'b0;
    for (int k = 0; k < 3; k++) begin
      ext_capture();
      check("R6 override across ext reset", boot_area, 2'b00);
      sb_capture();
      check("R6 override across standby", boot_area, 2'b00);
    end
    apply(6'b010011);
    ext_capture();
    check("R4 override then empty", boot_area, 2'b01);
    apply(6'b100010);
    ext_capture();
    check("R1 lock with override", boot_area, 2'b00);
    for (int i = 0; i < 64; i++) begin
      apply(6'(i));
      ext_capture();
      check($sformatf("R6 armed row %0d", i), boot_area, expect_area(6'(i), 1'b1));
    end

    @(negedge clk) por_n = 1'b0;
    @(negedge clk);
    check("R7 por clears valid", {1'b0, boot_valid}, 2'b00);
    check("R7 por clears area", boot_area, 2'b00);
    por_n = 1'b1;
    apply(6'b000010);
    ext_capture();
    check("R7 por disarms override", boot_area, 2'b10);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule